// File: doc/BRIEF.md
# SPI Command Frame Master

This block is the host end of a serial link to a gate-driver target. The system side presents one request at a time: a read/write flag, a 4-bit register address and, for writes, 8 bits of data. The block forms the 16-bit command word from these fields and pulls chip select low. It shifts the word out MSB first while collecting the 16 bits the target returns, then releases chip select. The received word appears on `rdata` with a one-cycle `done` pulse.

The serial clock idles low. Each bit lasts `div + 1` module clock cycles, and a `div` of zero is treated as one. The divider is latched when a request is accepted. Before the first clock pulse and after the last one, chip select stays asserted for a guard interval while the serial clock is held low. A `busy` flag covers the whole frame, and any request that arrives while it is high is dropped.

Top module: `spi_cmd_master`

## Requirements
- R1: A read request (`rnw`=1) sends a word with bit 15 = 1, bits 14:11 = address and bits 10:0 = 0.
- R2: A write request (`rnw`=0) sends a word with bit 15 = 0, bits 14:11 = address, bits 10:8 = 0 and bits 7:0 = `wdata`.
- R3: Every frame has exactly 16 serial clock pulses and sends the word MSB first. `mosi` changes only on rising `sclk` edges, so the target captures it on falling edges.
- R4: `sclk` is low whenever `cs_n` is high, and it is low at both edges of `cs_n`.
- R5: The `sclk` period is P = `div`+1 module clock cycles, with `div`=0 giving P = 2. The high phase lasts floor(P/2) cycles. `div` is captured when the request is accepted, and later changes do not affect the frame in flight.
- R6: `miso` is sampled on each falling `sclk` edge, MSB first. The 16 sampled bits appear on `rdata` in the cycle where `done` is high.
- R7: The first rising `sclk` edge comes exactly P cycles after `cs_n` falls. `cs_n` rises 2P - floor(P/2) cycles (at least P) after the last falling `sclk` edge.
- R8: `busy` is high from the cycle after acceptance until the frame ends. A request seen while busy is ignored: it changes neither the frame in flight nor starts another.
- R9: `done` is high for exactly one cycle, on the same edge at which `cs_n` rises and `busy` falls. After reset, `cs_n`=1, `sclk`=0, `busy`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, taken only while idle |
| rnw | input | 1 | 1 = read command, 0 = write command |
| addr | input | ADDR_W | Target register address |
| wdata | input | DATA_W | Write data |
| div | input | DIV_W | Bit-rate divider; bit period is div+1 cycles |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | FRAME_W | Word received from the target |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the target |
| miso | input | 1 | Serial data from the target |

## Verification
The hardest case to reach is a request that arrives in the middle of a frame, with a different command and a different divider. A correct design hides such a request completely. The bench fires one partway through the shift phase, with the address inverted, the command flipped and a new divider. It then checks three things: the word the modelled target captured, the measured bit period, and that `cs_n` stays high for several bit periods afterwards. Edge placement is checked with even, odd and zero divider values, by timing the `sclk` and `cs_n` transitions in module clock cycles.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TRAIL = 2'd3
    } spi_state_e;
endpackage

// File: rtl/spi_cmd_word.sv
module spi_cmd_word #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int FRAME_W = 16
) (
    input  logic               rnw,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [FRAME_W-1:0] word
);
    localparam int ADDR_LSB = FRAME_W - 1 - ADDR_W;

    always_comb begin
        word = '0;
        word[FRAME_W-1] = rnw;
        word[ADDR_LSB +: ADDR_W] = addr;
        if (!rnw) begin
            word[DATA_W-1:0] = wdata;
        end
    end
endmodule

// File: rtl/spi_bit_timer.sv
module spi_bit_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] period_m1,
    output logic [DIV_W-1:0] cnt_q,
    output logic [DIV_W-1:0] cnt_nxt,
    output logic             wrap
);
    logic [DIV_W-1:0] cnt_d;

    always_comb begin
        wrap = run && (cnt_q == period_m1);
        if (!run || wrap) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
        cnt_nxt = cnt_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= period_m1));
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
    import spi_cmd_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int FRAME_W = 16,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               rnw,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DIV_W-1:0]   div,
    output logic               busy,
    output logic               done,
    output logic [FRAME_W-1:0] rdata,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi,
    input  logic               miso
);
    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_W - 1);

    typedef struct packed {
        spi_state_e         st;
        logic [BIT_W-1:0]   bit_n;
        logic [FRAME_W-1:0] tx;
        logic [FRAME_W-1:0] rx;
        logic [DIV_W-1:0]   per;
        logic               sclk;
        logic               cs_n;
        logic               mosi;
        logic               busy;
        logic               done;
        logic [FRAME_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [FRAME_W-1:0] cmd_word;
    logic [DIV_W-1:0]   cnt_q, cnt_nxt;
    logic               wrap;
    logic [DIV_W:0]     hi_len;
    logic [DIV_W:0]     hi_m1;

    spi_cmd_word #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .FRAME_W(FRAME_W)
    ) u_word (
        .rnw  (rnw),
        .addr (addr),
        .wdata(wdata),
        .word (cmd_word)
    );

    spi_bit_timer #(
        .DIV_W(DIV_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (r_q.st != ST_IDLE),
        .period_m1(r_q.per),
        .cnt_q    (cnt_q),
        .cnt_nxt  (cnt_nxt),
        .wrap     (wrap)
    );

    always_comb begin
        hi_len = ({1'b0, r_q.per} + 1'b1) >> 1;
        hi_m1  = hi_len - 1'b1;
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    r_d.st    = ST_LEAD;
                    r_d.tx    = cmd_word;
                    r_d.per   = (div == '0) ? DIV_W'(1) : div;
                    r_d.bit_n = LAST_IDX;
                    r_d.rx    = '0;
                    r_d.cs_n  = 1'b0;
                    r_d.mosi  = cmd_word[FRAME_W-1];
                end
            end
            ST_LEAD: begin
                if (wrap) begin
                    r_d.st = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if ({1'b0, cnt_q} == hi_m1) begin
                    r_d.rx = {r_q.rx[FRAME_W-2:0], miso};
                end
                if (wrap) begin
                    if (r_q.bit_n == '0) begin
                        r_d.st   = ST_TRAIL;
                        r_d.mosi = 1'b0;
                    end else begin
                        r_d.bit_n = r_q.bit_n - 1'b1;
                        r_d.tx    = r_q.tx << 1;
                        r_d.mosi  = r_q.tx[FRAME_W-2];
                    end
                end
            end
            ST_TRAIL: begin
                if (wrap) begin
                    r_d.st    = ST_IDLE;
                    r_d.cs_n  = 1'b1;
                    r_d.done  = 1'b1;
                    r_d.rdata = r_q.rx;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        r_d.busy = (r_d.st != ST_IDLE);
        r_d.sclk = (r_d.st == ST_SHIFT) && ({1'b0, cnt_nxt} < hi_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.cs_n  <= 1'b1;
            r_q.per   <= DIV_W'(1);
            r_q.bit_n <= LAST_IDX;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy  = r_q.busy;
    assign done  = r_q.done;
    assign rdata = r_q.rdata;
    assign sclk  = r_q.sclk;
    assign cs_n  = r_q.cs_n;
    assign mosi  = r_q.mosi;

    // R4
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R4
    cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (!sclk && !$past(sclk)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !busy && !sclk));

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SHIFT || r_q.st == ST_TRAIL) |=> (r_q.st != ST_LEAD));

    // R3
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_TRAIL) |-> (r_q.bit_n == '0 && !sclk));
endmodule

// File: tb/spi_cmd_master_bench.sv
module spi_cmd_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        rnw = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  div = 8'd3;
    logic        busy, done, sclk, cs_n, mosi;
    logic        miso = 1'b0;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // target model state
    logic [15:0] resp = '0;
    logic [15:0] cap = '0;
    int fall_n = 0, rise_n = 0, edge_err = 0;
    int t_csfall = 0, t_csrise = 0, t_first_rise = 0;
    int t_rise_prev = 0, t_rise_last = 0, t_last_fall = 0;

    always #2 clk = ~clk;
    always @(negedge clk) cyc++;

    spi_cmd_master u_spi_cmd_master (
        .clk(clk), .rst_n(rst_n), .req(req), .rnw(rnw), .addr(addr),
        .wdata(wdata), .div(div), .busy(busy), .done(done), .rdata(rdata),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    always @(negedge cs_n) begin
        if (sclk === 1'b1) edge_err++;
        t_csfall = cyc;
        fall_n = 0;
        rise_n = 0;
        cap = '0;
        miso = resp[15];
    end

    always @(posedge cs_n) begin
        if (sclk === 1'b1) edge_err++;
        t_csrise = cyc;
    end

    always @(posedge sclk) begin
        if (cs_n !== 1'b0) begin
            edge_err++;
        end else begin
            if (rise_n == 0) t_first_rise = cyc;
            t_rise_prev = t_rise_last;
            t_rise_last = cyc;
            if (fall_n > 0 && fall_n < 16) miso = resp[15 - fall_n];
            rise_n++;
        end
    end

    always @(negedge sclk) begin
        if (cs_n === 1'b0) begin
            cap = {cap[14:0], mosi};
            fall_n++;
            t_last_fall = cyc;
        end
    end

    task automatic chk(string rq, bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic test_reset();
        chk("R9", cs_n === 1'b1, "reset cs_n", int'(cs_n), 1);
        chk("R9", sclk === 1'b0, "reset sclk", int'(sclk), 0);
        chk("R9", busy === 1'b0, "reset busy", int'(busy), 0);
        chk("R9", done === 1'b0, "reset done", int'(done), 0);
    endtask

    task automatic run_frame(bit rd, logic [3:0] a, logic [7:0] d, logic [7:0] dv,
                             logic [15:0] rsp, bit late_req, logic [7:0] dv_late);
        logic [15:0] exp_word;
        int p, hi, guard;
        p  = (dv == 0) ? 2 : int'(dv) + 1;
        hi = p / 2;
        exp_word = rd ? {1'b1, a, 11'd0} : {1'b0, a, 3'd0, d};
        @(negedge clk);
        resp = rsp; req = 1'b1; rnw = rd; addr = a; wdata = d; div = dv;
        @(negedge clk);
        req = 1'b0;
        chk("R8", busy === 1'b1, "busy after accept", int'(busy), 1);
        if (late_req) begin
            repeat (5 * p) @(negedge clk);
            req = 1'b1; rnw = ~rd; addr = ~a; wdata = ~d; div = dv_late;
            @(negedge clk);
            req = 1'b0;
        end
        guard = 0;
        while (done !== 1'b1 && guard < 40 * p + 100) begin
            @(negedge clk);
            guard++;
        end
        chk("R9", done === 1'b1, "done seen", int'(done), 1);
        chk("R9", busy === 1'b0 && cs_n === 1'b1, "busy/cs at done", int'({busy, cs_n}), 1);
        chk("R6", rdata == rsp, "rdata", int'(rdata), int'(rsp));
        chk(rd ? "R1" : "R2", cap == exp_word, "captured word", int'(cap), int'(exp_word));
        chk("R3", rise_n == 16 && fall_n == 16, "pulse count", rise_n, 16);
        chk("R5", t_rise_last - t_rise_prev == p, "bit period", t_rise_last - t_rise_prev, p);
        chk("R5", t_last_fall - t_rise_last == hi, "high width", t_last_fall - t_rise_last, hi);
        chk("R7", t_first_rise - t_csfall == p, "lead", t_first_rise - t_csfall, p);
        chk("R7", t_csrise - t_last_fall == 2 * p - hi, "trail", t_csrise - t_last_fall, 2 * p - hi);
        chk("R4", edge_err == 0, "sclk at cs edges", edge_err, 0);
        @(negedge clk);
        chk("R9", done === 1'b0, "done one cycle", int'(done), 0);
        if (late_req) begin
            for (int i = 0; i < 4 * p; i++) begin
                @(negedge clk);
                if (cs_n !== 1'b1 || busy !== 1'b0) begin
                    chk("R8", 1'b0, "late request started frame", int'({busy, cs_n}), 1);
                    break;
                end
            end
            chk("R8", cs_n === 1'b1, "idle after ignored request", int'(cs_n), 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        run_frame(1'b0, 4'h5, 8'hA5, 8'd3,  16'h1234, 1'b0, 8'd0);
        run_frame(1'b1, 4'hF, 8'h77, 8'd24, 16'hBEEF, 1'b0, 8'd0);
        run_frame(1'b0, 4'h0, 8'hFF, 8'd0,  16'h8001, 1'b0, 8'd0);
        run_frame(1'b1, 4'h9, 8'h00, 8'd1,  16'h5A5A, 1'b0, 8'd0);
        // R5 divider change mid-frame and R8 request while busy
        run_frame(1'b0, 4'h3, 8'h11, 8'd4,  16'hC3E1, 1'b1, 8'd9);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule